// File: doc/BRIEF.md
# Seconds-and-Hundredths Stopwatch Core

This block measures elapsed time from a free-running system clock and presents it as four decimal digits: tens of seconds, units of seconds, tenths and hundredths. A divide-by-N prescaler turns the clock into a one-cycle tick every 10 ms. Four chained modulus counters turn that tick into BCD digits, so the value shown runs from 00.00 up to 59.99 and then wraps to 00.00.

A single run input starts and pauses timing. While it is low the prescaler holds its partial count, so a paused interval resumes where it stopped. A synchronous active-low reset clears everything. The prescaler and every digit come from one parameterized modulus counter. Its carry is combinational: it is high only when the counter is told to advance while already at its last value. The carry of each digit is the advance request of the next one, so a ripple from 09.99 to 10.00 settles in a single clock edge.

Top module: `sw_stopwatch`

## Requirements
- R1: When rst_n is low at a rising clock edge, every digit and the prescaler read 0 after that edge, whatever run is.
- R2: With run held high, the hundredths digit advances once every DIV clock cycles. DIV defaults to 1,000,000, which is 10 ms at 100 MHz. The first advance after reset comes on the DIV-th running edge.
- R3: A counter at MOD-1 that is told to advance goes to 0 on that edge.
- R4: A counter whose advance request is low keeps its value.
- R5: A counter's carry is high only in a cycle where its advance request is high and its value is MOD-1. The next digit therefore changes on the same edge as the wrapping digit.
- R6: digit0 (hundredths), digit1 (tenths) and digit2 (seconds) count modulo 10. digit3 (tens of seconds) counts modulo 6. Every digit is a 4-bit binary value from 0 to 9.
- R7: While run is low, neither the prescaler nor any digit changes.
- R8: When the display reads 59.99, the next tick returns all four digits to 0 on one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to let time advance, low to pause |
| digit0 | output | 4 | Hundredths of a second, BCD |
| digit1 | output | 4 | Tenths of a second, BCD |
| digit2 | output | 4 | Units of seconds, BCD |
| digit3 | output | 4 | Tens of seconds, BCD (0 to 5) |

## Verification
Two pairs of events can fall in the same cycle. A reset can arrive on the very edge where the prescaler tick would ripple a carry through the digits. A full carry chain, from the 9 in the hundredths up through the wrap at 59.99, resolves on one edge. The bench uses a small divisor and steers reset low exactly when the prescaler sits at its last count and the hundredths digit is 9. It also runs the watch, with pauses, through a complete 60-second wrap. A behavioural model is compared against all four digits after every edge. Reset must win the collision, and every digit of a ripple must change together on the edge the model predicts.

// File: rtl/sw_pkg.sv
// Shared constants for the stopwatch core.
// Assumes four BCD digits; the most significant counts tens of seconds.
package sw_pkg;
    localparam int NUM_DIGITS = 4;
    localparam int DIGIT_W    = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Modulus of digit position idx: top digit wraps at 6, the rest at 10.
    function automatic int digit_mod(input int idx);
        return (idx == NUM_DIGITS - 1) ? 6 : 10;
    endfunction
endpackage

// File: rtl/sw_modcnt.sv
// Generic modulus counter: counts 0..MOD-1 on each cycle that inc is high.
// carry is combinational (inc AND at last value) so chained stages advance
// together. Assumes MOD >= 2 and MOD <= 2**W. Reset is synchronous, active low.
module sw_modcnt #(
    parameter int MOD = 10,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         carry
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic at_last;

    // Detect terminal value.
    always_comb at_last = (count == LAST);

    // Carry out only when asked to step while at the terminal value.
    always_comb carry = inc && at_last;

    // Count register with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (inc)     count <= at_last ? '0 : count + 1'b1;
    end

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == LAST) |=> (count == '0));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
    a_r5_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (count == '0));
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
endmodule

// File: rtl/sw_digit_chain.sv
// Chain of BCD digit counters. Each stage's carry is the next stage's
// increment. Assumes the tick input is a single-cycle pulse.
module sw_digit_chain
    import sw_pkg::*;
#(
    parameter int N = NUM_DIGITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [N-1:0][3:0]  digits,
    output logic               wrap_all
);
    logic [N:0] link;

    // Feed the tick into the least significant stage.
    always_comb link[0] = tick;

    for (genvar i = 0; i < N; i++) begin : g_digit
        sw_modcnt #(
            .MOD (digit_mod(i)),
            .W   (DIGIT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (link[i]),
            .count (digits[i]),
            .carry (link[i+1])
        );
    end

    // Whole display wraps when the top stage carries.
    always_comb wrap_all = link[N];

    a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_all |=> (digits == '0));
    a_r5_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (link[1] && !link[2]) |=> (digits[0] == '0 && digits[1] != $past(digits[1])));
endmodule

// File: rtl/sw_stopwatch.sv
// Stopwatch core: prescaler divides clk down to a tick every DIV cycles
// (10 ms at 100 MHz by default), which drives a four-digit BCD chain.
// Assumes run is synchronous to clk. Reset is synchronous, active low.
module sw_stopwatch
    import sw_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 100,
    parameter int DIV     = CLK_HZ / TICK_HZ
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [3:0] digit0,
    output logic [3:0] digit1,
    output logic [3:0] digit2,
    output logic [3:0] digit3
);
    localparam int PRE_W = $clog2(DIV);

    logic [PRE_W-1:0]              pre_cnt;
    logic                          tick;
    logic [NUM_DIGITS-1:0][3:0]    digits;
    logic                          wrap_all;

    sw_modcnt #(
        .MOD (DIV),
        .W   (PRE_W)
    ) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (run),
        .count (pre_cnt),
        .carry (tick)
    );

    sw_digit_chain #(
        .N (NUM_DIGITS)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .digits   (digits),
        .wrap_all (wrap_all)
    );

    // Break the packed digit vector out to named ports.
    always_comb begin
        digit0 = digits[0];
        digit1 = digits[1];
        digit2 = digits[2];
        digit3 = digits[3];
    end

    a_r7_pause_pre: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pre_cnt));
    a_r7_pause_digits: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable({digit3, digit2, digit1, digit0}));
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> ({digit3, digit2, digit1, digit0} == '0 && pre_cnt == '0));
    a_r8_wrap_seen: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_all |-> (digit3 == 4'd5 && digit0 == 4'd9));
endmodule

// File: tb/sw_stopwatch_bench.sv
module sw_stopwatch_bench;
    localparam int  DIV       = 5;
    localparam time CLK_PER   = 10ns;
    localparam int  WATCHDOG  = 150_000;

    logic clk = 0;
    logic rst_n = 0;
    logic run = 0;
    logic [3:0] digit0, digit1, digit2, digit3;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Behavioural model state.
    int m_pre = 0;
    int m_d[4] = '{0, 0, 0, 0};
    string phase = "R1";

    sw_stopwatch #(.DIV(DIV)) u_sw_stopwatch (
        .clk(clk), .rst_n(rst_n), .run(run),
        .digit0(digit0), .digit1(digit1), .digit2(digit2), .digit3(digit3)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Reference model: step on each rising edge from the stimulus in force.
    always @(posedge clk) begin
        bit t;
        if (!rst_n) begin
            m_pre = 0;
            for (int i = 0; i < 4; i++) m_d[i] = 0;
        end else if (run) begin
            t = (m_pre == DIV - 1);
            m_pre = t ? 0 : m_pre + 1;
            for (int i = 0; i < 4; i++) begin
                int md;
                bit nt;
                md = (i == 3) ? 6 : 10;
                nt = t && (m_d[i] == md - 1);
                if (t) m_d[i] = (m_d[i] == md - 1) ? 0 : m_d[i] + 1;
                t = nt;
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            vectors++;
            if (digit0 !== 4'(m_d[0]) || digit1 !== 4'(m_d[1]) ||
                digit2 !== 4'(m_d[2]) || digit3 !== 4'(m_d[3])) begin
                miscompares++;
                $display("FAIL %s: got %0d%0d.%0d%0d expected %0d%0d.%0d%0d", phase,
                         digit3, digit2, digit1, digit0, m_d[3], m_d[2], m_d[1], m_d[0]);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        int lfsr = 32'h1ACE;
        // R1: reset state, with run high during reset.
        @(negedge clk); run = 1;
        step(3);
        rst_n = 1; run = 0;
        step(4);
        // R2 R3 R5 R6: free run, ticks every DIV cycles, ripples into digit1.
        phase = "R2/R3/R5/R6 run";
        run = 1;
        step(DIV * 250);
        // R4 R7: irregular pausing; digits and prescaler hold while paused.
        phase = "R4/R7 pause";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run = lfsr[0] | lfsr[3];
            step(1);
        end
        // R8: run through 59.99 and the full wrap to 00.00.
        phase = "R8 wrap";
        run = 1;
        for (int i = 0; i < 40000 && !(m_d[3] == 5 && m_d[2] == 9 && m_d[1] == 9
                                       && m_d[0] == 9 && m_pre == DIV - 1); i++)
            step(1);
        step(1);
        if (digit3 !== 0 || digit2 !== 0 || digit1 !== 0 || digit0 !== 0) begin
            miscompares++;
            $display("FAIL R8: got %0d%0d.%0d%0d expected 00.00",
                     digit3, digit2, digit1, digit0);
        end
        vectors++;
        step(DIV * 30);
        // R1: reset colliding with a tick and a carry out of digit0.
        phase = "R1 collision";
        for (int i = 0; i < 200 && !(m_pre == DIV - 1 && m_d[0] == 9); i++) step(1);
        rst_n = 0;
        step(1);
        vectors++;
        if ({digit3, digit2, digit1, digit0} !== 16'h0) begin
            miscompares++;
            $display("FAIL R1: got %h expected 0000", {digit3, digit2, digit1, digit0});
        end
        rst_n = 1;
        phase = "R2 restart";
        step(DIV * 40);
        finish_run();
    end
endmodule